// File: doc/BRIEF.md
# Shared-Unit Arithmetic Step Sequencer

This block runs a fixed chain of four dependent operations for a programmed number of loop passes: c = a*b, d = b*f, g = c/a and k = g + d. Only one multiplier, one divider and one adder exist. A step register, decoded like a program counter, selects the operands of each unit, starts it and waits for its completion flag. The multiplier and divider are iterative shift-add and restoring shift-subtract units. Each takes one clock per operand bit.

After a pass, the new k replaces b for the next pass, while a and f stay fixed. Once the first product c is ready, the second product d and the quotient g run together because they use different units. The addition waits until both have finished. The caller loads operands and a pass count and pulses `start`. It then waits for the one-cycle `done` pulse and reads the registered results.

Top module: `shared_arith_seq`

## Requirements
- R1: Each pass computes c = (a*b) mod 2^16, d = (b*f) mod 2^16, g = floor(c/a) and k = (g+d) mod 2^16, using 16-bit unsigned operands. The outputs show the values of the last pass.
- R2: Within a pass, g is computed from the c of that same pass, and k from the g and d of that same pass.
- R3: Between passes, k is copied into b, and a and f keep their start values. After n passes, the outputs equal n chained evaluations of R1.
- R4: With 16-bit operands, `done` goes high exactly 36*n clock edges after the edge that captures an accepted `start` with pass count n > 0.
- R5: When a = 0, the quotient g is 0xFFFF and the latency is unchanged. `div_by_zero` then goes to 1 and stays 1 until the next accepted `start` clears it.
- R6: `done` is high for exactly one cycle, and `busy` is 0 while `done` is high. `busy` is 1 from the cycle after an accepted `start` with n > 0 until `done`.
- R7: A `start` seen while `busy` is 1 is ignored. The running job keeps its operands, its results and its latency.
- R8: A `start` with pass count 0 raises `done` on the capturing edge, never raises `busy`, and leaves c, d, g and k unchanged.
- R9: After reset, `busy`, `done`, `div_by_zero` and all four results are 0.
- R10: A multiply or divide is only issued to its unit while that unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job when idle |
| iter_count | input | 8 | Number of passes |
| a_in | input | 16 | Initial a (multiplicand and divisor) |
| b_in | input | 16 | Initial b (replaced by k each pass) |
| f_in | input | 16 | Constant f |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| c_out | output | 16 | Last c |
| d_out | output | 16 | Last d |
| g_out | output | 16 | Last g |
| k_out | output | 16 | Last k |
| div_by_zero | output | 1 | Sticky divide-by-zero flag |

## Verification
Random full-range operands with one to three passes check the wrap of products and sums and the feedback of k into b. A single pass shows whether g is built from the fresh c rather than a stale one. Directed cases cover several patterns:
- a = 0 separates the divide-by-zero path and its sticky flag from normal division.
- b = 0, all-ones operands and a = 1 cover the quotient boundaries.
- A count of zero and a second `start` pulsed mid-job show that idle handling and busy lockout leave the results and the latency untouched.

// File: rtl/shared_arith_pkg.sv
package shared_arith_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_MUL_C   = 3'd1,
    ST_WAIT_C  = 3'd2,
    ST_WAIT_DG = 3'd3,
    ST_ADD     = 3'd4
  } step_t;
endpackage

// File: rtl/iter_mul.sv
module iter_mul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] product
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     acc_q, mcand_q, mplier_q;
  logic [CNT_W-1:0] cnt_q;

  // one shift-add step: add the shifted multiplicand when the multiplier bit is set
  function automatic logic [W-1:0] mac_step(input logic [W-1:0] acc,
                                            input logic [W-1:0] mcand,
                                            input logic         bit_i);
    return acc + (bit_i ? mcand : '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        acc_q    <= '0;
        mcand_q  <= op_a;
        mplier_q <= op_b;
        cnt_q    <= '0;
        busy     <= 1'b1;
      end else if (busy) begin
        acc_q    <= mac_step(acc_q, mcand_q, mplier_q[0]);
        mcand_q  <= mcand_q << 1;
        mplier_q <= mplier_q >> 1;
        cnt_q    <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign product = acc_q;
endmodule

// File: rtl/iter_div.sv
module iter_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic         zero_div
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q, quo_q, dvs_q;
  logic [CNT_W-1:0] cnt_q;

  // one restoring step: shift in the next dividend bit, subtract if it fits
  function automatic logic [2*W-1:0] sub_step(input logic [W-1:0] rem,
                                              input logic [W-1:0] quo,
                                              input logic [W-1:0] dvs);
    logic [W:0] shifted;
    logic [W:0] diff;
    shifted = {rem, quo[W-1]};
    diff    = shifted - {1'b0, dvs};
    if (shifted >= {1'b0, dvs})
      return {diff[W-1:0], quo[W-2:0], 1'b1};
    else
      return {shifted[W-1:0], quo[W-2:0], 1'b0};
  endfunction

  logic [2*W-1:0] nxt;
  assign nxt = sub_step(rem_q, quo_q, dvs_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      quo_q    <= '0;
      dvs_q    <= '0;
      cnt_q    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      zero_div <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        rem_q    <= '0;
        quo_q    <= dividend;
        dvs_q    <= divisor;
        cnt_q    <= '0;
        busy     <= 1'b1;
        zero_div <= (divisor == '0);
      end else if (busy) begin
        rem_q <= nxt[2*W-1:W];
        quo_q <= nxt[W-1:0];
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;
endmodule

// File: rtl/shared_arith_seq.sv
module shared_arith_seq
  import shared_arith_pkg::*;
#(
  parameter int W      = 16,
  parameter int ITER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ITER_W-1:0] iter_count,
  input  logic [W-1:0]      a_in,
  input  logic [W-1:0]      b_in,
  input  logic [W-1:0]      f_in,
  output logic              busy,
  output logic              done,
  output logic [W-1:0]      c_out,
  output logic [W-1:0]      d_out,
  output logic [W-1:0]      g_out,
  output logic [W-1:0]      k_out,
  output logic              div_by_zero
);
  step_t             step;
  logic [W-1:0]      a_q, b_q, f_q, c_q, d_q, g_q, k_q;
  logic [ITER_W-1:0] left_q;
  logic              got_mul, got_div;

  // shared-unit handshake wires, also watched by the checker
  logic         mul_go, mul_busy, mul_done;
  logic         div_go, div_busy, div_done, div_zero;
  logic [W-1:0] mul_op_a, mul_op_b, mul_prod, div_quo;
  logic [W-1:0] add_sum;

  // operand multiplexers, selected by the step register
  assign mul_op_a = (step == ST_MUL_C) ? a_q : b_q;
  assign mul_op_b = (step == ST_MUL_C) ? b_q : f_q;
  assign mul_go   = (step == ST_MUL_C) || ((step == ST_WAIT_C) && mul_done);
  assign div_go   = (step == ST_WAIT_C) && mul_done;
  assign add_sum  = g_q + d_q;

  iter_mul #(.W(W)) i_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go),
    .op_a(mul_op_a), .op_b(mul_op_b),
    .busy(mul_busy), .done(mul_done), .product(mul_prod)
  );

  iter_div #(.W(W)) i_div (
    .clk(clk), .rst_n(rst_n), .go(div_go),
    .dividend(mul_prod), .divisor(a_q),
    .busy(div_busy), .done(div_done), .quotient(div_quo), .zero_div(div_zero)
  );

  logic mul_ok, div_ok;
  assign mul_ok = got_mul || mul_done;
  assign div_ok = got_div || div_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step        <= ST_IDLE;
      a_q         <= '0;
      b_q         <= '0;
      f_q         <= '0;
      c_q         <= '0;
      d_q         <= '0;
      g_q         <= '0;
      k_q         <= '0;
      left_q      <= '0;
      got_mul     <= 1'b0;
      got_div     <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      case (step)
        ST_IDLE: begin
          if (start) begin
            a_q         <= a_in;
            b_q         <= b_in;
            f_q         <= f_in;
            left_q      <= iter_count;
            div_by_zero <= 1'b0;
            if (iter_count == '0) begin
              done <= 1'b1;
            end else begin
              busy <= 1'b1;
              step <= ST_MUL_C;
            end
          end
        end
        ST_MUL_C: step <= ST_WAIT_C;
        ST_WAIT_C: begin
          if (mul_done) begin
            c_q     <= mul_prod;
            got_mul <= 1'b0;
            got_div <= 1'b0;
            step    <= ST_WAIT_DG;
          end
        end
        ST_WAIT_DG: begin
          if (mul_done) begin
            d_q     <= mul_prod;
            got_mul <= 1'b1;
          end
          if (div_done) begin
            g_q     <= div_quo;
            got_div <= 1'b1;
            if (div_zero) div_by_zero <= 1'b1;
          end
          if (mul_ok && div_ok) step <= ST_ADD;
        end
        ST_ADD: begin
          k_q    <= add_sum;
          left_q <= left_q - ITER_W'(1);
          if (left_q == ITER_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            step <= ST_IDLE;
          end else begin
            b_q  <= add_sum;
            step <= ST_MUL_C;
          end
        end
        default: step <= ST_IDLE;
      endcase
    end
  end

  assign c_out = c_q;
  assign d_out = d_q;
  assign g_out = g_q;
  assign k_out = k_q;
endmodule

// File: rtl/shared_arith_seq_checker.sv
module shared_arith_seq_checker
  import shared_arith_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         mul_go,
  input logic         mul_busy,
  input logic         mul_done,
  input logic         div_go,
  input logic         div_busy,
  input step_t        step,
  input logic [W-1:0] a_q,
  input logic [W-1:0] k_q
);
  a_r10_mul_idle_issue: assert property (@(posedge clk) disable iff (!rst_n)
    mul_go |-> !mul_busy);

  a_r10_div_idle_issue: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> !div_busy);

  a_r2_div_uses_fresh_c: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> mul_done);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_start_locked_out: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(a_q));

  a_r1_k_from_add_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(k_q) |-> $past(step == ST_ADD));
endmodule

bind shared_arith_seq shared_arith_seq_checker #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mul_go(mul_go), .mul_busy(mul_busy), .mul_done(mul_done),
  .div_go(div_go), .div_busy(div_busy), .step(step), .a_q(a_q), .k_q(k_q)
);

// File: tb/test_shared_arith_seq.sv
module test_shared_arith_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  iter_count = '0;
  logic [15:0] a_in = '0, b_in = '0, f_in = '0;
  logic        busy, done, div_by_zero;
  logic [15:0] c_out, d_out, g_out, k_out;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  shared_arith_seq i_shared_arith_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .iter_count(iter_count),
    .a_in(a_in), .b_in(b_in), .f_in(f_in), .busy(busy), .done(done),
    .c_out(c_out), .d_out(d_out), .g_out(g_out), .k_out(k_out),
    .div_by_zero(div_by_zero)
  );

  // reference: n chained passes, k fed into b, divide by zero gives all ones
  function automatic logic [63:0] model(input logic [15:0] a, input logic [15:0] b0,
                                        input logic [15:0] f, input int n);
    logic [15:0] b = b0, c = 0, d = 0, g = 0, k = 0;
    logic [31:0] pc, pd;
    for (int i = 0; i < n; i++) begin
      pc = a * b;  c = pc[15:0];
      pd = b * f;  d = pd[15:0];
      g  = (a == 0) ? 16'hFFFF : c / a;
      k  = 16'(g + d);
      b  = k;
    end
    return {c, d, g, k};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] a, input logic [15:0] b, input logic [15:0] f,
                     input int n, input bit glitch);
    logic [63:0] exp_v, prev;
    int cyc;
    prev  = {c_out, d_out, g_out, k_out};
    exp_v = (n == 0) ? prev : model(a, b, f, n);
    a_in = a; b_in = b; f_in = f; iter_count = 8'(n); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == (n != 0), "R6 busy after start", 64'(busy), 64'(n != 0));
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (glitch && cyc == 5) begin
        start = 1'b1; a_in = ~a; b_in = ~b; iter_count = 8'd1;
      end else begin
        start = 1'b0;
      end
    end
    check(cyc == 36 * n, n == 0 ? "R8 zero count done" : "R4 latency",
          64'(cyc), 64'(36 * n));
    check(!busy, "R6 busy low at done", 64'(busy), 64'd0);
    check({c_out, d_out, g_out, k_out} == exp_v,
          n == 0 ? "R8 results held" : (glitch ? "R7 results" : "R1 R3 results"),
          {c_out, d_out, g_out, k_out}, exp_v);
    if (n != 0)
      check(div_by_zero == (a == 0), "R5 div_by_zero flag", 64'(div_by_zero),
            64'(a == 0));
    @(posedge clk);
    @(negedge clk);
    check(!done, "R6 done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({busy, done, div_by_zero} == 3'b0, "R9 reset flags",
          64'({busy, done, div_by_zero}), 64'd0);
    check({c_out, d_out, g_out, k_out} == 64'd0, "R9 reset results",
          {c_out, d_out, g_out, k_out}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(16'd7, 16'd9, 16'd3, 1, 1'b0);            // R1 R2 single pass
    run(16'hFFFF, 16'hFFFF, 16'hFFFF, 1, 1'b0);   // R1 wrap
    run(16'd1, 16'd1234, 16'd5, 2, 1'b0);         // R3 a=1 quotient equals c
    run(16'd13, 16'd0, 16'd99, 2, 1'b0);          // R1 b=0
    run(16'd0, 16'd77, 16'd4, 2, 1'b0);           // R5 divide by zero
    repeat (4) @(negedge clk);
    check(div_by_zero, "R5 sticky while idle", 64'(div_by_zero), 64'd1);
    run(16'd5, 16'd6, 16'd7, 0, 1'b0);            // R8 zero count, clears flag
    check(!div_by_zero, "R5 cleared by start", 64'(div_by_zero), 64'd0);
    run(16'd300, 16'd451, 16'd29, 3, 1'b1);       // R7 start while busy
    for (int i = 0; i < 25; i++) begin
      logic [15:0] ra, rb, rf;
      ra = 16'($urandom);
      rb = 16'($urandom);
      rf = 16'($urandom);
      if (i % 5 == 0) ra = 16'($urandom_range(1, 40));
      run(ra, rb, rf, int'($urandom_range(1, 3)), 1'b0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule